// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block sits beside a 16550-style serial port. It gathers the port's interrupt causes: receive line errors, received data or character time-out, an empty transmit holding register, and modem-status changes. It masks them with a four-bit enable register and reports the most urgent enabled cause as an identification byte. The serial shifters, FIFOs and baud logic are outside the block. They supply strobes and levels on dedicated inputs.

Software reaches the block over a byte-wide register bus with a 3-bit offset. The read data follows the offset without a register stage. The block also decodes the bus accesses that retire causes: a write to the transmit holding offset, and reads of the line-status and modem-status offsets. Those registers are owned elsewhere. The single interrupt output is high while any enabled cause is pending, so an interrupt handler can read the identification byte in a loop until bit 0 reads 1.

Top module: `uart_irq_ident`

## Requirements
- R1: The enable register sits at offset 1. Bit 0 enables the receive-data and time-out cause, bit 1 the transmit-empty cause, bit 2 the line-status cause, and bit 3 the modem-status cause. Bits 7:4 read as 0, and the register resets to 0x00.
- R2: The identification byte is read at offset 2. Bit 0 is 1 when no enabled cause is pending. After reset, with the FIFO flag low, it reads 0x01.
- R3: The low nibble of the identification byte gives the cause: 0x6 line status, 0x4 received data available, 0xC character time-out, 0x2 transmit empty, 0x0 modem status. Bits 5:4 read as 0.
- R4: When several enabled causes are pending, the nibble reports the highest one. The order is line status, then received data, then time-out, then transmit empty, then modem status.
- R5: Bits 7:6 of the identification byte read 11 while `fifo_on` is high and 00 while it is low.
- R6: `irq` is high exactly when at least one enabled cause is pending.
- R7: A transmit-empty strobe latches a pending cause. A write to offset 0 clears it. A read of offset 2 that reports code 0x2 also clears it. A read of offset 2 that reports a different cause leaves it pending.
- R8: A line-error strobe latches a cause that a read of offset 5 clears. A modem-change strobe latches a cause that a read of offset 6 clears.
- R9: A disabled cause does not affect `irq` or the identification byte, but its latch keeps it. Enabling it later makes it visible.
- R10: When a set strobe and a clearing access for the same cause fall in one cycle, the cause stays pending.
- R11: Received data and time-out are levels. Their codes follow `rx_ready` and `rx_timeout` with no latching. Data available takes precedence when both are high.
- R12: Reads of any offset other than 1 and 2 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| line_err_evt | input | 1 | One-cycle pulse: receiver saw a line error |
| rx_ready | input | 1 | Level: receive data at or above the trigger point |
| rx_timeout | input | 1 | Level: character time-out condition |
| tx_empty_evt | input | 1 | One-cycle pulse: transmit holding register became empty |
| modem_chg_evt | input | 1 | One-cycle pulse: a modem input changed |
| fifo_on | input | 1 | FIFOs enabled |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case is a transmit-empty cause that sits behind a higher cause. An identification read must clear it only when the read reports it. The bench latches line status and transmit empty together, then reads offset 2 and sees line status. It retires line status through offset 5 and reads offset 2 again, expecting transmit empty to be still pending. A third read must then report nothing pending. Same-cycle collisions of a set strobe with its clearing access are driven deliberately, on one negative edge, so that both land on the same capturing edge.

// File: rtl/uart_irq_pkg.sv
// Package: shared cause codes and register offsets of the interrupt
// identification unit. Assumes a 3-bit register offset.
package uart_irq_pkg;
    typedef enum logic [3:0] {
        CAUSE_MS   = 4'h0,
        CAUSE_NONE = 4'h1,
        CAUSE_THR  = 4'h2,
        CAUSE_RDA  = 4'h4,
        CAUSE_LS   = 4'h6,
        CAUSE_CTO  = 4'hC
    } cause_e;

    localparam int ADDR_W    = 3;
    localparam int EN_W      = 4;
    localparam int N_LATCH   = 3;   // latched causes: line, transmit, modem
    localparam int LAT_LS    = 0;
    localparam int LAT_THR   = 1;
    localparam int LAT_MS    = 2;

    localparam logic [ADDR_W-1:0] OFF_TXH   = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_EN    = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_IDENT = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_LSTAT = 3'd5;
    localparam logic [ADDR_W-1:0] OFF_MSTAT = 3'd6;
endpackage

// File: rtl/uart_irq_latch.sv
// Module: sticky pending flag for one event-driven interrupt cause.
// Assumes set and clear are single-cycle strobes; set wins on collision.
module uart_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    // Hold the cause from its strobe until a clearing access retires it.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_o <= 1'b0;
        else if (set_i)  pend_o <= 1'b1;
        else if (clr_i)  pend_o <= 1'b0;
    end
endmodule

// File: rtl/uart_irq_prio.sv
// Module: fixed-priority selector of the most urgent enabled cause.
// Assumes enable bit 0 rx, 1 tx, 2 line, 3 modem; purely combinational.
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [EN_W-1:0] en_i,
    input  logic            ls_i,
    input  logic            rda_i,
    input  logic            cto_i,
    input  logic            thr_i,
    input  logic            ms_i,
    output cause_e          cause_o
);
    // Pick the highest enabled pending cause, or none.
    always_comb begin
        if (en_i[2] && ls_i)        cause_o = CAUSE_LS;
        else if (en_i[0] && rda_i)  cause_o = CAUSE_RDA;
        else if (en_i[0] && cto_i)  cause_o = CAUSE_CTO;
        else if (en_i[1] && thr_i)  cause_o = CAUSE_THR;
        else if (en_i[3] && ms_i)   cause_o = CAUSE_MS;
        else                        cause_o = CAUSE_NONE;
    end
endmodule

// File: rtl/uart_irq_ident.sv
// Module: interrupt identification unit of a 16550-style UART. Latches
// event causes, masks them with the enable register, reports the top
// cause on the register bus and drives the interrupt line.
// Assumes one-cycle bus strobes and combinational read data.
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              line_err_evt,
    input  logic              rx_ready,
    input  logic              rx_timeout,
    input  logic              tx_empty_evt,
    input  logic              modem_chg_evt,
    input  logic              fifo_on,
    output logic              irq
);
    logic [EN_W-1:0]    en_q;
    logic [N_LATCH-1:0] lat_set;
    logic [N_LATCH-1:0] lat_clr;
    logic [N_LATCH-1:0] lat_pend;
    cause_e             cause;
    logic [7:0]         ident_now;
    logic               ident_rd;

    assign ident_rd = bus_rd && (bus_addr == OFF_IDENT);

    // Enable register: written at its offset, low bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (bus_wr && bus_addr == OFF_EN)
            en_q <= bus_wdata[EN_W-1:0];
    end

    // Route event strobes and retiring accesses to each latch.
    always_comb begin
        lat_set[LAT_LS]  = line_err_evt;
        lat_set[LAT_THR] = tx_empty_evt;
        lat_set[LAT_MS]  = modem_chg_evt;
        lat_clr[LAT_LS]  = bus_rd && bus_addr == OFF_LSTAT;
        lat_clr[LAT_THR] = (bus_wr && bus_addr == OFF_TXH) ||
                           (ident_rd && cause == CAUSE_THR);
        lat_clr[LAT_MS]  = bus_rd && bus_addr == OFF_MSTAT;
    end

    for (genvar g = 0; g < N_LATCH; g++) begin : g_lat
        uart_irq_latch u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (lat_set[g]),
            .clr_i (lat_clr[g]),
            .pend_o(lat_pend[g])
        );
    end

    uart_irq_prio u_prio (
        .en_i   (en_q),
        .ls_i   (lat_pend[LAT_LS]),
        .rda_i  (rx_ready),
        .cto_i  (rx_timeout),
        .thr_i  (lat_pend[LAT_THR]),
        .ms_i   (lat_pend[LAT_MS]),
        .cause_o(cause)
    );

    // Identification byte: FIFO flags on top, cause code below.
    assign ident_now = {{2{fifo_on}}, 2'b00, cause};

    // Interrupt line: any enabled cause, computed apart from the selector.
    assign irq = (en_q[2] & lat_pend[LAT_LS])  |
                 (en_q[0] & (rx_ready | rx_timeout)) |
                 (en_q[1] & lat_pend[LAT_THR]) |
                 (en_q[3] & lat_pend[LAT_MS]);

    // Read multiplexer for the two registers this unit owns.
    always_comb begin
        case (bus_addr)
            OFF_EN:    bus_rdata = {{(8-EN_W){1'b0}}, en_q};
            OFF_IDENT: bus_rdata = ident_now;
            default:   bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/uart_irq_ident_chk.sv
// Module: property checker bound to the identification unit.
// Assumes it observes the unit's ports and internal cause state.
module uart_irq_ident_chk
    import uart_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              line_err_evt,
    input logic              tx_empty_evt,
    input logic              modem_chg_evt,
    input logic              fifo_on,
    input logic              irq,
    input logic [EN_W-1:0]   en_q,
    input logic [N_LATCH-1:0] lat_pend,
    input logic [7:0]        ident_now
);
    AST_IRQ_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !ident_now[0]);                                           // R6
    AST_FIFO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ident_now[7:6] == {2{fifo_on}});                                  // R5
    AST_LS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[2] && lat_pend[LAT_LS]) |-> ident_now[3:0] == 4'h6);        // R4
    AST_LS_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFF_LSTAT && !line_err_evt)
        |=> ident_now[3:0] != 4'h6);                                       // R8
    AST_MS_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFF_MSTAT && !modem_chg_evt)
        |=> !lat_pend[LAT_MS]);                                            // R8
    AST_THR_WRITE_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_TXH && !tx_empty_evt)
        |=> ident_now[3:0] != 4'h2);                                       // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err_evt && en_q[2] && !(bus_wr && bus_addr == OFF_EN))
        |=> ident_now[3:0] == 4'h6);                                       // R10
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .line_err_evt (line_err_evt),
    .tx_empty_evt (tx_empty_evt),
    .modem_chg_evt(modem_chg_evt),
    .fifo_on      (fifo_on),
    .irq          (irq),
    .en_q         (en_q),
    .lat_pend     (lat_pend),
    .ident_now    (ident_now)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       line_err_evt = 1'b0, rx_ready = 1'b0, rx_timeout = 1'b0;
    logic       tx_empty_evt = 1'b0, modem_chg_evt = 1'b0, fifo_on = 1'b0;
    logic       irq;
    int         n_run = 0, n_fail = 0;
    logic [7:0] got;

    always #2 clk = ~clk;   // 250 MHz

    uart_irq_ident u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_err_evt(line_err_evt), .rx_ready(rx_ready),
        .rx_timeout(rx_timeout), .tx_empty_evt(tx_empty_evt),
        .modem_chg_evt(modem_chg_evt), .fifo_on(fifo_on), .irq(irq)
    );

    // Vector: {en[3:0], ls, rda, cto, thr, ms, fifo, expected ident[7:0]}
    localparam logic [17:0] VEC [0:11] = '{
        {4'hF, 6'b000000, 8'h01},   // R2 nothing pending
        {4'hF, 6'b100000, 8'h06},   // R3 line status
        {4'hF, 6'b110110, 8'h06},   // R4 line status beats all
        {4'hF, 6'b011100, 8'h04},   // R4 R11 data beats time-out
        {4'hF, 6'b001110, 8'h0C},   // R4 time-out beats transmit
        {4'hF, 6'b000110, 8'h02},   // R4 transmit beats modem
        {4'hF, 6'b000010, 8'h00},   // R3 modem status
        {4'h0, 6'b111110, 8'h01},   // R9 all masked
        {4'h8, 6'b110110, 8'h00},   // R9 only modem enabled
        {4'h2, 6'b000101, 8'hC2},   // R5 fifo flags, transmit
        {4'h1, 6'b001001, 8'hCC},   // R5 R11 fifo flags, time-out
        {4'h4, 6'b010000, 8'h01}    // R9 data with only line enabled
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic ls, input logic thr, input logic ms);
        @(negedge clk);
        line_err_evt = ls; tx_empty_evt = thr; modem_chg_evt = ms;
        @(negedge clk);
        line_err_evt = 1'b0; tx_empty_evt = 1'b0; modem_chg_evt = 1'b0;
    endtask

    task automatic scrub();
        logic [7:0] dummy;
        rx_ready = 1'b0; rx_timeout = 1'b0;
        rd(3'd5, dummy); rd(3'd6, dummy); wr(3'd0, 8'h00);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        rd(3'd1, got); chk("R1 reset enable", got, 8'h00);
        rd(3'd2, got); chk("R2 reset ident", got, 8'h01);
        chk("R6 reset irq", {7'd0, irq}, 8'h00);
        rd(3'd3, got); chk("R12 other offset", got, 8'h00);

        // Table walk
        for (int i = 0; i < 12; i++) begin
            scrub();
            wr(3'd1, {4'h0, VEC[i][17:14]});
            fifo_on = VEC[i][8];
            pulse(VEC[i][13], VEC[i][10], VEC[i][9]);
            rx_ready = VEC[i][12]; rx_timeout = VEC[i][11];
            @(negedge clk); #1;
            chk("R6 irq vs vector", {7'd0, irq}, {7'd0, ~VEC[i][0]});
            rd(3'd2, got);
            chk("R3 R4 ident vector", got, VEC[i][7:0]);
        end
        fifo_on = 1'b0;

        // R1 upper bits of enable read zero
        scrub();
        wr(3'd1, 8'hFF); rd(3'd1, got); chk("R1 enable width", got, 8'h0F);

        // R7 ident read reporting transmit clears it
        pulse(1'b0, 1'b1, 1'b0);
        rd(3'd2, got); chk("R7 thr reported", got, 8'h02);
        rd(3'd2, got); chk("R7 thr cleared by read", got, 8'h01);

        // R7 read reporting a higher cause keeps transmit pending
        pulse(1'b1, 1'b1, 1'b0);
        rd(3'd2, got); chk("R7 line first", got, 8'h06);
        rd(3'd5, got);
        rd(3'd2, got); chk("R7 thr survives other read", got, 8'h02);
        rd(3'd2, got); chk("R7 then cleared", got, 8'h01);

        // R7 write to offset 0 clears transmit
        pulse(1'b0, 1'b1, 1'b0);
        wr(3'd0, 8'h55);
        rd(3'd2, got); chk("R7 thr cleared by write", got, 8'h01);

        // R8 line and modem retire on their reads
        pulse(1'b1, 1'b0, 1'b1);
        rd(3'd5, got);
        rd(3'd2, got); chk("R8 line retired, modem left", got, 8'h00);
        rd(3'd6, got);
        rd(3'd2, got); chk("R8 modem retired", got, 8'h01);
        chk("R6 irq low after retire", {7'd0, irq}, 8'h00);

        // R9 masked modem cause stays latched
        wr(3'd1, 8'h07);
        pulse(1'b0, 1'b0, 1'b1);
        rd(3'd2, got); chk("R9 masked modem hidden", got, 8'h01);
        wr(3'd1, 8'h0F);
        rd(3'd2, got); chk("R9 modem shown when enabled", got, 8'h00);
        rd(3'd6, got);

        // R10 set strobe collides with clearing read
        @(negedge clk);
        bus_addr = 3'd5; bus_rd = 1'b1; line_err_evt = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; line_err_evt = 1'b0;
        rd(3'd2, got); chk("R10 line set wins", got, 8'h06);
        rd(3'd5, got);
        @(negedge clk);
        bus_addr = 3'd0; bus_wr = 1'b1; tx_empty_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tx_empty_evt = 1'b0;
        rd(3'd2, got); chk("R10 thr set wins", got, 8'h02);

        // R11 data level removal drops the cause at once
        scrub();
        rx_ready = 1'b1;
        rd(3'd2, got); chk("R11 data level", got, 8'h04);
        rx_ready = 1'b0;
        rd(3'd2, got); chk("R11 level gone", got, 8'h01);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule